// File: doc/BRIEF.md
# Clock-Gated Partitioned ALU

This block is a sixteen-operation integer ALU. Its datapath is split into four functional groups, each with its own result register. The two upper bits of the 4-bit opcode pick the group, and the two lower bits pick the operation inside that group. On a cycle with the input strobe high, only the addressed group is clocked. The three idle groups keep their registers frozen, so those registers see no switching activity.

The groups are two arithmetic groups, one bitwise-logic group and one single-step shift/rotate group. A small output multiplexer presents the registered result of the group that took the most recent valid operation. One cycle after the strobe, the result, the upper product half, the carry/borrow flag and a result-valid flag appear at the outputs.

A parameter selects how the gating is built. It can be a glitch-free gated clock made from a latched enable, or a plain per-group clock enable on the free-running clock.

Top module: `cg_part_alu`

## Requirements
- R1: Opcodes 0..3 form the first arithmetic group: 0 gives a+b with carry-out on cout, 1 gives a-b with borrow (a<b) on cout, 2 gives a+1 with carry-out (a all ones) on cout, and 3 gives a-1 with borrow (a zero) on cout. Results are modulo 2^W and res_hi is 0.
- R2: Opcode 4 multiplies a by b as unsigned values. The low W bits of the product go on res, the high W bits on res_hi, and cout is 0.
- R3: Opcode 5 gives a+b+cin with carry-out on cout. Opcode 6 drives res to all zeros and opcode 7 drives res to all ones. For opcodes 6 and 7, cout is 0. res_hi is 0 for all three.
- R4: Opcodes 8..11 give the bitwise functions: 8 is the complement of a, 9 is a AND b, 10 is a OR b and 11 is a XOR b. cout and res_hi are 0.
- R5: Opcodes 12..15 move a by one bit position. 12 shifts toward the MSB with zero fill, 13 shifts toward the LSB with zero fill, 14 rotates toward the MSB with the old MSB entering bit 0, and 15 rotates toward the LSB with the old bit 0 entering the MSB. cout and res_hi are 0.
- R6: For an input accepted at a rising edge with in_valid high, res, res_hi and cout show its result after that edge, and res_valid is high for exactly that following cycle.
- R7: At most one group is clocked per cycle, namely the group chosen by op[3:2], and only while in_valid is high. Back-to-back valid operations to different groups each produce their own correct result in consecutive cycles.
- R8: While in_valid is low, op, a, b and cin are ignored: res, res_hi and cout hold their previous values and res_valid is 0.
- R9: While reset (rst_n low) is asserted, res, res_hi and cout are 0 and res_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 4 | Opcode; bits [3:2] pick the group |
| a | input | W | First operand |
| b | input | W | Second operand |
| cin | input | 1 | Carry-in for add with carry |
| res | output | W | Result (low half of product for multiply) |
| res_hi | output | W | High half of product, else 0 |
| cout | output | 1 | Carry or borrow flag |
| res_valid | output | 1 | Result valid, one cycle after in_valid |

## Verification
With W set to 4, every opcode is swept over every operand pair and both carry-in values. Back-to-back issue covers the carry, borrow and wrap boundaries of each operation and separates the shift results from the rotate results. A second run cycles the opcode on every cycle so that consecutive operations go to different groups. This shows that the output multiplexer follows the most recently clocked group and does not return stale data from an idle one. Idle cycles with scrambled operands and opcode then show that unstrobed inputs cannot disturb the held outputs.

// File: rtl/cg_alu_pkg.sv
package cg_alu_pkg;
   localparam int OP_W   = 4;
   localparam int SUB_W  = 2;
   localparam int N_GRP  = 1 << (OP_W - SUB_W);

   typedef enum logic [OP_W-SUB_W-1:0] {
      GRP_ARITH_A = 2'd0,
      GRP_ARITH_B = 2'd1,
      GRP_LOGIC   = 2'd2,
      GRP_SHIFT   = 2'd3
   } grp_e;
endpackage

// File: rtl/cg_alu_decode.sv
module cg_alu_decode
   import cg_alu_pkg::*;
(
   input  logic                in_valid,
   input  logic [OP_W-1:0]     op,
   output logic [N_GRP-1:0]    grp_en,
   output logic [SUB_W-1:0]    sub_op
);
   localparam int GSEL_W = OP_W - SUB_W;

   logic [GSEL_W-1:0] gsel;

   assign gsel   = op[OP_W-1:SUB_W];
   assign sub_op = op[SUB_W-1:0];

   always_comb begin
      grp_en = '0;
      for (int g = 0; g < N_GRP; g++) begin
         if (in_valid && (gsel == GSEL_W'(g))) grp_en[g] = 1'b1;
      end
   end
endmodule

// File: rtl/cg_alu_clkgate.sv
module cg_alu_clkgate #(
   parameter bit USE_LATCH = 1'b0
) (
   input  logic clk,
   input  logic en,
   output logic gclk,
   output logic ce
);
   generate
      if (USE_LATCH) begin : g_latch
         logic en_l;
         always_latch begin
            if (!clk) en_l = en;
         end
         assign gclk = clk & en_l;
         assign ce   = 1'b1;
      end else begin : g_enable
         assign gclk = clk;
         assign ce   = en;
      end
   endgenerate
endmodule

// File: rtl/cg_alu_group.sv
module cg_alu_group
   import cg_alu_pkg::*;
#(
   parameter int W   = 8,
   parameter int GID = 0
) (
   input  logic             gclk,
   input  logic             ce,
   input  logic             rst_n,
   input  logic [SUB_W-1:0] sub_op,
   input  logic [W-1:0]     a,
   input  logic [W-1:0]     b,
   input  logic             cin,
   output logic [W-1:0]     q_lo,
   output logic [W-1:0]     q_hi,
   output logic             q_c
);
   localparam int WE = W + 1;
   localparam int WP = 2 * W;

   logic [W-1:0] nx_lo;
   logic [W-1:0] nx_hi;
   logic         nx_c;

   generate
      if (GID == int'(GRP_ARITH_A)) begin : g_arith_a
         logic [WE-1:0] ext;
         always_comb begin
            unique case (sub_op)
               2'd0:    ext = {1'b0, a} + {1'b0, b};
               2'd1:    ext = {1'b0, a} - {1'b0, b};
               2'd2:    ext = {1'b0, a} + WE'(1);
               default: ext = {1'b0, a} - WE'(1);
            endcase
            nx_lo = ext[W-1:0];
            nx_c  = ext[W];
            nx_hi = '0;
         end
      end else if (GID == int'(GRP_ARITH_B)) begin : g_arith_b
         logic [WP-1:0] prod;
         logic [WE-1:0] sum;
         assign prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
         assign sum  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
         always_comb begin
            nx_hi = '0;
            nx_c  = 1'b0;
            unique case (sub_op)
               2'd0: begin
                  nx_lo = prod[W-1:0];
                  nx_hi = prod[WP-1:W];
               end
               2'd1: begin
                  nx_lo = sum[W-1:0];
                  nx_c  = sum[W];
               end
               2'd2:    nx_lo = '0;
               default: nx_lo = '1;
            endcase
         end
      end else if (GID == int'(GRP_LOGIC)) begin : g_logic
         always_comb begin
            unique case (sub_op)
               2'd0:    nx_lo = ~a;
               2'd1:    nx_lo = a & b;
               2'd2:    nx_lo = a | b;
               default: nx_lo = a ^ b;
            endcase
            nx_hi = '0;
            nx_c  = 1'b0;
         end
      end else begin : g_shift
         always_comb begin
            unique case (sub_op)
               2'd0:    nx_lo = {a[W-2:0], 1'b0};
               2'd1:    nx_lo = {1'b0, a[W-1:1]};
               2'd2:    nx_lo = {a[W-2:0], a[W-1]};
               default: nx_lo = {a[0], a[W-1:1]};
            endcase
            nx_hi = '0;
            nx_c  = 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge gclk or negedge rst_n) begin
      if (!rst_n) begin
         q_lo <= '0;
         q_hi <= '0;
         q_c  <= 1'b0;
      end else if (ce) begin
         q_lo <= nx_lo;
         q_hi <= nx_hi;
         q_c  <= nx_c;
      end
   end
endmodule

// File: rtl/cg_part_alu.sv
module cg_part_alu
   import cg_alu_pkg::*;
#(
   parameter int W         = 8,
   parameter bit USE_LATCH = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [3:0]      op,
   input  logic [W-1:0]    a,
   input  logic [W-1:0]    b,
   input  logic            cin,
   output logic [W-1:0]    res,
   output logic [W-1:0]    res_hi,
   output logic            cout,
   output logic            res_valid
);
   localparam int GSEL_W = OP_W - SUB_W;

   generate
      if (W < 2) begin : g_bad_width
         $error("cg_part_alu: W must be at least 2");
      end
      if (OP_W != 4) begin : g_bad_op
         $error("cg_part_alu: opcode must be 4 bits");
      end
   endgenerate

   logic [N_GRP-1:0] grp_en;
   logic [SUB_W-1:0] sub_op;
   logic [W-1:0]     lo_arr [N_GRP];
   logic [W-1:0]     hi_arr [N_GRP];
   logic             c_arr  [N_GRP];
   logic [GSEL_W-1:0] sel_q;
   logic             valid_q;

   cg_alu_decode u_dec (
      .in_valid (in_valid),
      .op       (op),
      .grp_en   (grp_en),
      .sub_op   (sub_op)
   );

   generate
      for (genvar g = 0; g < N_GRP; g++) begin : g_grp
         logic gclk;
         logic ce;
         cg_alu_clkgate #(.USE_LATCH(USE_LATCH)) u_cg (
            .clk  (clk),
            .en   (grp_en[g]),
            .gclk (gclk),
            .ce   (ce)
         );
         cg_alu_group #(.W(W), .GID(g)) u_grp (
            .gclk   (gclk),
            .ce     (ce),
            .rst_n  (rst_n),
            .sub_op (sub_op),
            .a      (a),
            .b      (b),
            .cin    (cin),
            .q_lo   (lo_arr[g]),
            .q_hi   (hi_arr[g]),
            .q_c    (c_arr[g])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= GSEL_W'(GRP_ARITH_A);
         valid_q <= 1'b0;
      end else begin
         valid_q <= in_valid;
         if (in_valid) sel_q <= op[OP_W-1:SUB_W];
      end
   end

   assign res       = lo_arr[sel_q];
   assign res_hi    = hi_arr[sel_q];
   assign cout      = c_arr[sel_q];
   assign res_valid = valid_q;
endmodule

module cg_part_alu_chk
   import cg_alu_pkg::*;
#(
   parameter int W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic [3:0]      op,
   input logic [W-1:0]    a,
   input logic [W-1:0]    b,
   input logic [W-1:0]    res,
   input logic [W-1:0]    res_hi,
   input logic            cout,
   input logic            res_valid,
   input logic [N_GRP-1:0] grp_en
);
   // R1
   a_r1_add: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 4'd0) |=> ({cout, res} == ($past({1'b0, a}) + $past({1'b0, b}))));

   // R2
   a_r2_mul: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 4'd4) |=>
      ({res_hi, res} == ($past({{W{1'b0}}, a}) * $past({{W{1'b0}}, b}))));

   // R3
   a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 4'd6) |=> (res == '0 && !cout));
   a_r3_set: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 4'd7) |=> (res == '1 && !cout));

   // R6
   a_r6_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> res_valid);

   // R7
   a_r7_one_group: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grp_en) && (in_valid || grp_en == '0));
   a_r7_right_group: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> grp_en[op[3:2]]);

   // R8
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(res) && $stable(res_hi) && $stable(cout) && !res_valid));
endmodule

bind cg_part_alu cg_part_alu_chk #(.W(W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op        (op),
   .a         (a),
   .b         (b),
   .res       (res),
   .res_hi    (res_hi),
   .cout      (cout),
   .res_valid (res_valid),
   .grp_en    (grp_en)
);

// File: tb/cg_part_alu_tb.sv
module cg_part_alu_tb_top;
   localparam int W = 4;
   localparam int MAXV = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [3:0]   op = '0;
   logic [W-1:0] a = '0;
   logic [W-1:0] b = '0;
   logic         cin = 1'b0;
   logic [W-1:0] res;
   logic [W-1:0] res_hi;
   logic         cout;
   logic         res_valid;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic         pend = 1'b0;
   logic [3:0]   e_op;
   int           e_lo, e_hi, e_c;

   always #2 clk = ~clk;

   cg_part_alu #(.W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .a(a), .b(b),
      .cin(cin), .res(res), .res_hi(res_hi), .cout(cout), .res_valid(res_valid)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic string req_of(input logic [3:0] o);
      if (o < 4)       return "R1";
      else if (o == 4) return "R2";
      else if (o < 8)  return "R3";
      else if (o < 12) return "R4";
      else             return "R5";
   endfunction

   task automatic model(input logic [3:0] o, input int x, input int y, input int ci,
                        output int lo, output int hi, output int c);
      int t;
      hi = 0; c = 0;
      case (o)
         4'd0:  begin t = x + y;      lo = t & MAXV; c = t >> W; end
         4'd1:  begin lo = (x - y) & MAXV; c = (x < y) ? 1 : 0; end
         4'd2:  begin lo = (x + 1) & MAXV; c = (x == MAXV) ? 1 : 0; end
         4'd3:  begin lo = (x - 1) & MAXV; c = (x == 0) ? 1 : 0; end
         4'd4:  begin t = x * y; lo = t & MAXV; hi = t >> W; end
         4'd5:  begin t = x + y + ci; lo = t & MAXV; c = t >> W; end
         4'd6:  lo = 0;
         4'd7:  lo = MAXV;
         4'd8:  lo = MAXV - x;
         4'd9:  lo = x & y;
         4'd10: lo = x | y;
         4'd11: lo = x ^ y;
         4'd12: lo = (x * 2) & MAXV;
         4'd13: lo = x / 2;
         4'd14: lo = ((x * 2) & MAXV) + (x >> (W - 1));
         default: lo = (x / 2) + ((x & 1) << (W - 1));
      endcase
   endtask

   task automatic check_pending(input string tag);
      if (pend) begin
         chk(tag == "" ? req_of(e_op) : tag, "res", int'(res), e_lo);
         chk(tag == "" ? req_of(e_op) : tag, "res_hi", int'(res_hi), e_hi);
         chk(tag == "" ? req_of(e_op) : tag, "cout", int'(cout), e_c);
         chk("R6", "res_valid", int'(res_valid), 1);
      end
   endtask

   task automatic issue(input logic [3:0] o, input int x, input int y, input int ci,
                        input string tag);
      @(negedge clk);
      check_pending(tag);
      in_valid = 1'b1; op = o; a = W'(x); b = W'(y); cin = ci[0];
      e_op = o;
      model(o, x, y, ci, e_lo, e_hi, e_c);
      pend = 1'b1;
   endtask

   task automatic print_summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9", "res", int'(res), 0);
      chk("R9", "res_hi", int'(res_hi), 0);
      chk("R9", "cout", int'(cout), 0);
      chk("R9", "res_valid", int'(res_valid), 0);
      rst_n = 1'b1;

      // Exhaustive sweep, issued back to back (R1..R5, R6)
      for (int o = 0; o < 16; o++)
         for (int x = 0; x <= MAXV; x++)
            for (int y = 0; y <= MAXV; y++)
               for (int ci = 0; ci < 2; ci++)
                  issue(4'(o), x, y, ci, "");

      // R7: opcode changes group every cycle
      for (int i = 0; i < 128; i++)
         issue(4'((i * 5 + 3) % 16), (i * 7) % 16, (i * 3 + 1) % 16, i % 2, "R7");

      // R8: idle cycles with scrambled inputs
      @(negedge clk);
      check_pending("R7");
      pend = 1'b0;
      for (int k = 0; k < 4; k++) begin
         in_valid = 1'b0; op = 4'(k * 5 + 6); a = W'(k * 3 + 1); b = W'(15 - k); cin = k[0];
         @(negedge clk);
         chk("R8", "res", int'(res), e_lo);
         chk("R8", "res_hi", int'(res_hi), e_hi);
         chk("R8", "cout", int'(cout), e_c);
         chk("R8", "res_valid", int'(res_valid), 0);
      end

      done = 1'b1;
      print_summary();
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R6 watchdog: actual=hung expected=finished");
         print_summary();
         $finish;
      end
   end
endmodule